// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side of a parallel flash and decides when a program or erase operation inside the device has finished. A pulse on `start` begins polling. The block then reads the device status byte over a simple request/acknowledge bus. Each poll is a pair of back-to-back reads. If bit 6 of the status byte holds the same value in both reads, the device has stopped toggling and the operation is complete.

If the bit changed between the two reads, the block looks at bit 5 of the second read, which the device sets when its own time limit has run out. When bit 5 is clear, the block starts another fresh pair of reads. When bit 5 is set, the block makes exactly one more pair of reads. This extra pair covers the case where toggling stopped in the same moment the time-limit bit rose. If that last pair is stable, the result is success. If it still toggles, the block writes the reset command byte 0xF0 to the status address and then reports failure.

The host also sets a limit on how many toggling pairs it will wait through. Reaching that limit gives a separate host-timeout result. The host can use `abort` to give up on polling. A later `start` then begins again from a fresh first read.

Top module: `tbit_poller`

## Requirements
- R1: While `rst_n` is low and after its release with no `start`, `bus_req`, `busy` and `done` are 0.
- R2: A `start` while idle raises `bus_req` one cycle later, with `bus_we`=0 and `bus_addr`=`stat_addr`. Only one transaction is open at a time. While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stay unchanged.
- R3: If bit 6 is equal in the first two reads, polling ends with `pass` after exactly two reads and no write.
- R4: If bit 6 differs within a pair and bit 5 of that pair's second read is 0, a new pair of reads follows. The value of bit 5 in a first read has no effect.
- R5: If bit 6 differs and bit 5 of the second read is 1, one more pair of reads follows. If bit 6 is equal in that pair, the result is `pass`.
- R6: If bit 6 still differs in that extra pair, the block writes 0xF0 to `stat_addr` (`bus_we`=1). After that write is acknowledged, it reports `fail`.
- R7: MAX_PAIRS pairs that toggle with bit 5 clear end with `host_tmo`, with no write issued.
- R8: An `abort` during a read ends polling when that read is acknowledged. No `done` follows, and `bus_req` and `busy` drop. The next `start` begins with a new first read and keeps no earlier value.
- R9: A `start` while polling is ignored. The number of reads and the result stay the same.
- R10: `done` is a one-cycle pulse, raised in the cycle after the acknowledge of the final transaction. Exactly one of `pass`, `fail` and `host_tmo` is high with it, and all three are low at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (pulse, honoured when idle) |
| abort | input | 1 | Abandon polling at the end of the current read |
| stat_addr | input | AW | Address used for status reads and the reset write |
| bus_req | output | 1 | Transaction request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | 8 | Write data (reset command) |
| bus_ack | input | 1 | Transaction acknowledge; read data valid with it |
| bus_rdata | input | 8 | Status byte read from the device |
| busy | output | 1 | Polling or reset write in progress |
| done | output | 1 | One-cycle end-of-poll pulse |
| pass | output | 1 | With `done`: operation completed |
| fail | output | 1 | With `done`: device timed out, reset written |
| host_tmo | output | 1 | With `done`: host pair limit reached |

## Verification
The bench drives its inputs and samples the outputs on the falling clock edge. `bus_req` is due one falling edge after `start`. `done` and its result flag are due exactly one falling edge after the edge at which the bench raised the final `bus_ack`, and must be gone one falling edge later. The bench logs the cycle of every acknowledge and compares the `done` cycle against that log, so a late or early result counts as a failure. A sweep covers every combination of bit 6 across eight reads and bit 5 across four pairs, with an acknowledge latency of either 0 or 1 cycles. An arithmetic model predicts the outcome, the number of reads and the write for each combination.

// File: rtl/tbit_pkg.sv
package tbit_pkg;

    typedef logic [7:0] stat_t;

    localparam int    TGL_POS = 6;       // toggling status bit
    localparam int    LIM_POS = 5;       // device time-limit bit
    localparam stat_t RST_CMD = 8'hF0;   // reset command byte

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD1,
        ST_RD2,
        ST_WR
    } st_e;

    typedef struct packed {
        st_e  st;
        logic t0;          // toggle bit from first read of the pair
        logic recheck;     // extra pair after time-limit bit seen
        logic abort_pend;
        logic done;
        logic pass;
        logic fail;
        logic htmo;
    } ctrl_s;

endpackage

// File: rtl/tbit_bus_port.sv
module tbit_bus_port
    import tbit_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic          issue_we,
    input  logic [AW-1:0] issue_addr,
    input  stat_t         issue_wdata,
    input  logic          bus_ack,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output stat_t         bus_wdata,
    output logic          cpl
);

    typedef struct packed {
        logic          req;
        logic          we;
        logic [AW-1:0] addr;
        stat_t         wdata;
    } port_s;

    port_s q, d;

    assign cpl = q.req & bus_ack;

    always_comb begin
        d = q;
        if (cpl) begin
            d.req = 1'b0;
        end
        if (issue) begin
            d.req   = 1'b1;
            d.we    = issue_we;
            d.addr  = issue_addr;
            d.wdata = issue_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign bus_req   = q.req;
    assign bus_we    = q.we;
    assign bus_addr  = q.addr;
    assign bus_wdata = q.wdata;

    // R2: open request is held steady until acknowledged
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

    // R2: a new transaction is only launched when none is open
    a_r2_single: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (!bus_req || bus_ack));

endmodule

// File: rtl/tbit_pair_ctr.sv
module tbit_pair_ctr #(
    parameter int MAX_PAIRS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int CW = $clog2(MAX_PAIRS + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == CW'(MAX_PAIRS - 1));

    // R7: the pair count never steps past the host limit
    a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !last);

endmodule

// File: rtl/tbit_ctrl.sv
module tbit_ctrl
    import tbit_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  logic  abort,
    input  stat_t rd_data,
    input  logic  cpl,
    input  logic  last,
    output logic  issue,
    output logic  issue_we,
    output stat_t issue_wdata,
    output logic  cnt_clr,
    output logic  cnt_inc,
    output logic  busy,
    output logic  done,
    output logic  pass,
    output logic  fail,
    output logic  htmo
);

    ctrl_s q, d;
    logic  abort_now;
    logic  same;

    assign abort_now   = q.abort_pend | abort;
    assign same        = (rd_data[TGL_POS] == q.t0);
    assign issue_wdata = RST_CMD;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.pass   = 1'b0;
        d.fail   = 1'b0;
        d.htmo   = 1'b0;
        issue    = 1'b0;
        issue_we = 1'b0;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                d.abort_pend = 1'b0;
                if (start) begin
                    d.st      = ST_RD1;
                    d.recheck = 1'b0;
                    issue     = 1'b1;
                    cnt_clr   = 1'b1;
                end
            end
            ST_RD1, ST_RD2: begin
                if (abort) d.abort_pend = 1'b1;
                if (cpl) begin
                    if (abort_now) begin
                        d.st         = ST_IDLE;
                        d.abort_pend = 1'b0;
                    end else if (q.st == ST_RD1) begin
                        d.t0  = rd_data[TGL_POS];
                        d.st  = ST_RD2;
                        issue = 1'b1;
                    end else if (same) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.pass = 1'b1;
                    end else if (q.recheck) begin
                        d.st     = ST_WR;
                        issue    = 1'b1;
                        issue_we = 1'b1;
                    end else if (rd_data[LIM_POS]) begin
                        d.recheck = 1'b1;
                        d.st      = ST_RD1;
                        issue     = 1'b1;
                    end else if (last) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.htmo = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                        d.st    = ST_RD1;
                        issue   = 1'b1;
                    end
                end
            end
            ST_WR: begin
                if (cpl) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    d.fail = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy = (q.st != ST_IDLE);
    assign done = q.done;
    assign pass = q.pass;
    assign fail = q.fail;
    assign htmo = q.htmo;

    // R10: one result flag with each done, none otherwise
    a_r10_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones({pass, fail, htmo}) == 1));
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !(pass || fail || htmo));

    // R6: failure is only reported after the reset write completes
    a_r6_fail_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WR && cpl) |=> (done && fail));

    // R8: an abort closes the read without a result
    a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_RD1 || q.st == ST_RD2) && cpl && abort_now) |=> (!done && !busy));

endmodule

// File: rtl/tbit_poller.sv
module tbit_poller
    import tbit_pkg::*;
#(
    parameter int AW        = 16,
    parameter int MAX_PAIRS = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic [AW-1:0] stat_addr,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [7:0]    bus_wdata,
    input  logic          bus_ack,
    input  logic [7:0]    bus_rdata,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic          fail,
    output logic          host_tmo
);

    logic  issue, issue_we, cpl, last, cnt_clr, cnt_inc;
    stat_t issue_wdata;

    tbit_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .abort       (abort),
        .rd_data     (bus_rdata),
        .cpl         (cpl),
        .last        (last),
        .issue       (issue),
        .issue_we    (issue_we),
        .issue_wdata (issue_wdata),
        .cnt_clr     (cnt_clr),
        .cnt_inc     (cnt_inc),
        .busy        (busy),
        .done        (done),
        .pass        (pass),
        .fail        (fail),
        .htmo        (host_tmo)
    );

    tbit_bus_port #(.AW(AW)) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue       (issue),
        .issue_we    (issue_we),
        .issue_addr  (stat_addr),
        .issue_wdata (issue_wdata),
        .bus_ack     (bus_ack),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .cpl         (cpl)
    );

    tbit_pair_ctr #(.MAX_PAIRS(MAX_PAIRS)) u_pairs (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .last  (last)
    );

endmodule

// File: tb/test_tbit_poller.sv
module test_tbit_poller;

    localparam int AW   = 8;
    localparam int MAXP = 3;
    localparam int SEQN = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          abort = 1'b0;
    logic [AW-1:0] stat_addr = 8'h5A;
    logic          bus_req, bus_we, busy, done, pass, fail, host_tmo;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata;
    logic          bus_ack = 1'b0;
    logic [7:0]    bus_rdata = 8'h00;

    int checks = 0;
    int errors = 0;

    // responder state
    logic [7:0] seq [SEQN];
    int rd_idx = 0, wr_cnt = 0, lat = 0, wcnt = 0, addr_bad = 0;
    logic [7:0]    last_wd = '0;
    logic [AW-1:0] last_wa = '0;
    int cyc = 0, last_ack_cyc = 0;

    always #2 clk = ~clk;

    tbit_poller #(.AW(AW), .MAX_PAIRS(MAXP)) i_tbit_poller (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .stat_addr(stat_addr), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .busy(busy), .done(done), .pass(pass),
        .fail(fail), .host_tmo(host_tmo)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // bus responder, acts on falling edges
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_req) begin
                if (wcnt >= lat) begin
                    wcnt = 0;
                    bus_ack = 1'b1;
                    last_ack_cyc = cyc;
                    if (bus_addr != stat_addr) addr_bad++;
                    if (bus_we) begin
                        wr_cnt++;
                        last_wd = bus_wdata;
                        last_wa = bus_addr;
                    end else begin
                        bus_rdata = (rd_idx < SEQN) ? seq[rd_idx] : 8'h00;
                        rd_idx++;
                    end
                end else begin
                    wcnt++;
                end
            end
        end
    end

    task automatic clr_resp();
        rd_idx = 0; wr_cnt = 0; wcnt = 0; addr_bad = 0; last_wd = '0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // waits for done; returns 1 if seen, capturing flags
    task automatic wait_done(output bit seen, output logic p, output logic f,
                             output logic h, output int at);
        seen = 0; p = 0; f = 0; h = 0; at = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            #0;
            if (done) begin
                seen = 1; p = pass; f = fail; h = host_tmo; at = cyc;
                break;
            end
        end
    endtask

    // expected outcome: 0 pass, 1 fail, 2 host timeout
    function automatic void model(input logic [11:0] code, output int res,
                                  output int nrd, output string tag);
        int pairs = 0;
        bit rc = 0;
        res = 2; nrd = 0; tag = "R7";
        for (int p = 0; p < 4; p++) begin
            nrd = 2 * p + 2;
            if (code[2*p] == code[2*p+1]) begin
                res = 0;
                tag = rc ? "R5" : ((p == 0) ? "R3" : "R4");
                return;
            end
            if (rc) begin
                res = 1; tag = "R6";
                return;
            end
            if (code[8+p]) begin
                rc = 1;
            end else begin
                pairs++;
                if (pairs == MAXP) begin
                    res = 2; tag = "R7";
                    return;
                end
            end
        end
    endfunction

    task automatic run_code(input logic [11:0] code);
        int res, nrd, at;
        string tag;
        bit seen;
        logic p, f, h;
        for (int i = 0; i < SEQN; i++) begin
            logic [7:0] v;
            v = 8'((i * 37 + int'(code)) & 8'h9F);
            if (i < 8) begin
                v[6] = code[i];
                v[5] = (i % 2 == 1) ? code[8 + i/2] : ~code[8 + i/2];
            end
            seq[i] = v;
        end
        lat = int'(code[3] ^ code[9]);
        clr_resp();
        model(code, res, nrd, tag);
        pulse_start();
        wait_done(seen, p, f, h, at);
        chk(seen, "R10 done seen", int'(seen), 1);
        chk(p == (res == 0), {tag, " pass flag"}, int'(p), int'(res == 0));
        chk(f == (res == 1), {tag, " fail flag"}, int'(f), int'(res == 1));
        chk(h == (res == 2), {tag, " host_tmo flag"}, int'(h), int'(res == 2));
        chk(rd_idx == nrd, {tag, " read count R4"}, rd_idx, nrd);
        chk(wr_cnt == int'(res == 1), {tag, " write count"}, wr_cnt, int'(res == 1));
        if (res == 1) chk(last_wd == 8'hF0 && last_wa == stat_addr, "R6 reset write",
                          int'(last_wd), 240);
        chk(addr_bad == 0, "R2 address", addr_bad, 0);
        chk(at == last_ack_cyc + 1, "R10 done timing", at, last_ack_cyc + 1);
        @(negedge clk);
        chk(!done && !pass && !fail && !host_tmo && !busy, "R10 pulse width",
            int'(done), 0);
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit seen;
        logic p, f, h;
        int at;
        for (int i = 0; i < SEQN; i++) seq[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(!bus_req && !busy && !done, "R1 in reset", int'(bus_req | busy | done), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!bus_req && !busy && !done, "R1 after reset", int'(bus_req | busy | done), 0);

        // R2 launch timing and R9 start while busy
        lat = 3; clr_resp();
        pulse_start();
        chk(bus_req && !bus_we && bus_addr == stat_addr && busy, "R2 launch",
            int'(bus_req), 1);
        @(negedge clk);
        pulse_start();
        wait_done(seen, p, f, h, at);
        chk(seen && p, "R9 result unchanged", int'(p), 1);
        chk(rd_idx == 2, "R9 read count", rd_idx, 2);
        repeat (10) @(negedge clk);
        chk(!bus_req && rd_idx == 2, "R9 no extra poll", rd_idx, 2);

        // R8 abort during second read, then fresh restart
        seq[0] = 8'h40; seq[1] = 8'h00; lat = 3; clr_resp();
        pulse_start();
        for (int i = 0; i < 50 && rd_idx < 1; i++) @(negedge clk);
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        wait_done(seen, p, f, h, at);
        chk(!seen, "R8 no done after abort", int'(seen), 0);
        chk(!bus_req && !busy, "R8 idle after abort", int'(busy), 0);
        chk(rd_idx == 2, "R8 open read completed", rd_idx, 2);
        seq[0] = 8'h00; seq[1] = 8'h00; seq[2] = 8'h40; seq[3] = 8'h00;
        clr_resp();
        pulse_start();
        wait_done(seen, p, f, h, at);
        chk(seen && p, "R8 restart passes", int'(p), 1);
        chk(rd_idx == 2, "R8 restart uses fresh reads", rd_idx, 2);

        // sweep of bit 6 over eight reads and bit 5 over four pairs
        for (int c = 0; c < 4096; c++) begin
            run_code(12'(c));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule